// File: doc/BRIEF.md
# Dual-Rail Precharge Substitution Layer

This block is the nonlinear layer of a 64-bit lightweight block cipher. It applies one 4-bit substitution to each of sixteen nibbles of the state in parallel. Every value inside the layer travels on a pair of wires: a positive rail and a negative rail. In the precharge phase both rails of every pair sit at zero. In the evaluation phase exactly one rail of each pair rises. The positive rail carries the bit and the negative rail carries its complement.

The substitution networks are built only from AND and OR gates working on rails. Inversion is a swap of the two rails, so every path is monotone. As a result, each evaluation toggles the same number of wires whatever the data is. An input from the surrounding logic, `eval_phase`, chooses between precharge and evaluation. The single-rail state enters through an encoder that is gated by the phase. The dual-rail result is held in an output register.

A two-state controller sequences the layer. PRECHARGE is the reset state, and in it the encoder drives every rail low. EVALUATE opens the encoder. The START transition goes from PRECHARGE to EVALUATE when `eval_phase` is 1, and on that edge the output register returns to all-zero rails. The FINISH transition goes from EVALUATE to PRECHARGE when `eval_phase` is 0, and on that edge the output register captures the evaluated rails. In every other case the register holds its value.

Top module: `wddl_sbox_layer`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `out_p`, `out_n` and `data_out` are all zero and `out_valid` and `rail_err` are 0.
- R2: On a FINISH edge (state EVALUATE, `eval_phase` 0), the register loads the substitution of the `data_in` value present at that edge. From the next cycle `out_valid` is 1.
- R3: The nibble mapping in hex is 0→C, 1→5, 2→6, 3→B, 4→9, 5→0, 6→A, 7→D, 8→3, 9→E, A→F, B→8, C→4, D→7, E→1, F→2.
- R4: Nibble i of the result, bits 4i+3..4i, depends only on bits 4i+3..4i of `data_in`.
- R5: On every edge that is neither START nor FINISH, `out_p` and `out_n` do not change, whatever `data_in` does.
- R6: On a START edge (state PRECHARGE, `eval_phase` 1), all output rails return to 0 and `out_valid` falls. While `out_valid` is 0, every rail is 0.
- R7: While `out_valid` is 1, `out_n` is the bitwise complement of `out_p`, so exactly one rail of each pair is high.
- R8: `rail_err` is 1 if any pair shows both rails high, or if `out_valid` is 1 and any pair shows both rails low. On a correct layer it stays 0.
- R9: `data_out` is the decoded result and equals `out_p`.
- R10: After reset the controller is in PRECHARGE. It moves to EVALUATE only when `eval_phase` is 1, and it returns to PRECHARGE only when `eval_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_phase | input | 1 | 1 = evaluate, 0 = precharge |
| data_in | input | 4*NUM_NIB | Single-rail state entering the layer |
| out_p | output | 4*NUM_NIB | Registered positive rails |
| out_n | output | 4*NUM_NIB | Registered negative rails |
| data_out | output | 4*NUM_NIB | Decoded single-rail result |
| out_valid | output | 1 | Register holds an evaluated result |
| rail_err | output | 1 | Illegal rail pair detected |

## Verification
The bench builds the layer with its default of sixteen nibbles, which gives the full 64-bit state. One sweep rotates all sixteen input codes through every nibble position, so each table entry is seen in each lane and any crossed lane stands out. Evaluation windows of different lengths, long precharge runs with changing data, and a reset in the middle of a run exercise the hold, clear and capture edges. These are compared every cycle against a behavioural phase model.

// File: rtl/wddl_pkg.sv
package wddl_pkg;

    localparam int NIB_W  = 4;
    localparam int NIB_VS = 16;

    typedef enum logic {
        PH_PRE  = 1'b0,
        PH_EVAL = 1'b1
    } phase_e;

    function automatic logic [3:0] sub_nib(input logic [3:0] x);
        logic [3:0] y;
        unique case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

    // minterms whose image has output bit k equal to val
    function automatic logic [NIB_VS-1:0] term_set(input int k, input logic val);
        logic [NIB_VS-1:0] s;
        logic [3:0] img;
        s = '0;
        for (int x = 0; x < NIB_VS; x++) begin
            img = sub_nib(x[3:0]);
            s[x] = (img[k] == val);
        end
        return s;
    endfunction

endpackage

// File: rtl/wddl_encoder.sv
module wddl_encoder #(
    parameter int W = 64
) (
    input  logic         phase_on,
    input  logic [W-1:0] din,
    output logic [W-1:0] enc_p,
    output logic [W-1:0] enc_n
);
    always_comb begin
        enc_p = din & {W{phase_on}};
        enc_n = ~din & {W{phase_on}};
    end

    always_comb begin
        if (!$isunknown({enc_p, enc_n}))
            p_enc_excl_r7: assert ((enc_p & enc_n) == '0)
                else $error("encoder drove both rails of a pair");
    end
endmodule

// File: rtl/wddl_sbox4.sv
module wddl_sbox4
    import wddl_pkg::*;
(
    input  logic [NIB_W-1:0] in_p,
    input  logic [NIB_W-1:0] in_n,
    output logic [NIB_W-1:0] out_p,
    output logic [NIB_W-1:0] out_n
);
    logic [NIB_VS-1:0] mt;

    // each minterm is an AND of one rail per input bit
    for (genvar x = 0; x < NIB_VS; x++) begin : g_term
        logic [NIB_W-1:0] lit;
        for (genvar b = 0; b < NIB_W; b++) begin : g_lit
            if ((x >> b) % 2 == 1) begin : g_pos
                assign lit[b] = in_p[b];
            end else begin : g_neg
                assign lit[b] = in_n[b];
            end
        end
        assign mt[x] = &lit;
    end

    // each output rail is an OR over its set of minterms
    for (genvar k = 0; k < NIB_W; k++) begin : g_out
        localparam logic [NIB_VS-1:0] ONES  = term_set(k, 1'b1);
        localparam logic [NIB_VS-1:0] ZEROS = term_set(k, 1'b0);
        assign out_p[k] = |(mt & ONES);
        assign out_n[k] = |(mt & ZEROS);
    end

    always_comb begin
        if (!$isunknown(mt))
            p_one_term_r3: assert ($onehot0(mt))
                else $error("more than one minterm active");
    end
endmodule

// File: rtl/wddl_rail_reg.sv
module wddl_rail_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         clr,
    input  logic [W-1:0] d_p,
    input  logic [W-1:0] d_n,
    output logic [W-1:0] q_p,
    output logic [W-1:0] q_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_p <= '0;
            q_n <= '0;
        end else if (cap) begin
            q_p <= d_p;
            q_n <= d_n;
        end else if (clr) begin
            q_p <= '0;
            q_n <= '0;
        end
    end

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cap) |=> (q_p == '0 && q_n == '0))
        else $error("register not precharged after start");
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !clr) |=> ($stable(q_p) && $stable(q_n)))
        else $error("register moved outside capture or clear");
endmodule

// File: rtl/wddl_rail_check.sv
module wddl_rail_check #(
    parameter int W = 64
) (
    input  logic         valid,
    input  logic [W-1:0] q_p,
    input  logic [W-1:0] q_n,
    output logic         err
);
    logic both_hi;
    logic both_lo;

    always_comb begin
        both_hi = |(q_p & q_n);
        both_lo = |(~(q_p | q_n));
        err     = both_hi | (valid & both_lo);
    end
endmodule

// File: rtl/wddl_sbox_layer.sv
module wddl_sbox_layer
    import wddl_pkg::*;
#(
    parameter  int NUM_NIB = 16,
    localparam int W       = NUM_NIB * NIB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval_phase,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] out_p,
    output logic [W-1:0] out_n,
    output logic [W-1:0] data_out,
    output logic         out_valid,
    output logic         rail_err
);
    phase_e st, st_nxt;
    logic   enc_on, cap, clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PH_PRE;
        else        st <= st_nxt;
    end

    // next state and controls
    always_comb begin
        st_nxt = st;
        enc_on = 1'b0;
        cap    = 1'b0;
        clr    = 1'b0;
        unique case (st)
            PH_PRE: begin
                if (eval_phase) begin
                    st_nxt = PH_EVAL;   // START
                    clr    = 1'b1;
                end
            end
            PH_EVAL: begin
                enc_on = 1'b1;
                if (!eval_phase) begin
                    st_nxt = PH_PRE;    // FINISH
                    cap    = 1'b1;
                end
            end
            default: st_nxt = PH_PRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   out_valid <= 1'b0;
        else if (cap) out_valid <= 1'b1;
        else if (clr) out_valid <= 1'b0;
    end

    logic [W-1:0] in_p, in_n, sb_p, sb_n;

    wddl_encoder #(.W(W)) u_enc (
        .phase_on (enc_on),
        .din      (data_in),
        .enc_p    (in_p),
        .enc_n    (in_n)
    );

    for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
        wddl_sbox4 u_sb (
            .in_p  (in_p[i*NIB_W +: NIB_W]),
            .in_n  (in_n[i*NIB_W +: NIB_W]),
            .out_p (sb_p[i*NIB_W +: NIB_W]),
            .out_n (sb_n[i*NIB_W +: NIB_W])
        );
    end

    wddl_rail_reg #(.W(W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .clr   (clr),
        .d_p   (sb_p),
        .d_n   (sb_n),
        .q_p   (out_p),
        .q_n   (out_n)
    );

    assign data_out = out_p;

    wddl_rail_check #(.W(W)) u_chk (
        .valid (out_valid),
        .q_p   (out_p),
        .q_n   (out_n),
        .err   (rail_err)
    );

    p_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_PRE && eval_phase) |=> (st == PH_EVAL))
        else $error("START not taken");
    p_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_PRE && !eval_phase) |=> (st == PH_PRE))
        else $error("left precharge without phase");
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_EVAL && !eval_phase) |=> out_valid)
        else $error("FINISH did not mark result");
    p_balance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($countones(out_p) + $countones(out_n)) == W))
        else $error("unbalanced rails while valid");
    p_precharged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ((out_p | out_n) == '0))
        else $error("rails high while not valid");
    p_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_err)
        else $error("illegal rail pair");
endmodule

// File: tb/sim_wddl_sbox_layer.sv
`timescale 1ns/1ps
module sim_wddl_sbox_layer;
    localparam int NIB = 16;
    localparam int W   = NIB * 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         eval_phase = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] out_p, out_n, data_out;
    logic         out_valid, rail_err;

    int checks = 0;
    int errors = 0;

    // model state
    bit           m_eval = 0;
    logic [W-1:0] m_q = '0;
    bit           m_valid = 0;

    always #2.5 clk = ~clk;

    wddl_sbox_layer #(.NUM_NIB(NIB)) u0 (
        .clk(clk), .rst_n(rst_n), .eval_phase(eval_phase), .data_in(data_in),
        .out_p(out_p), .out_n(out_n), .data_out(data_out),
        .out_valid(out_valid), .rail_err(rail_err)
    );

    function automatic logic [3:0] ref_nib(input logic [3:0] v);
        logic [3:0] t [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                              4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
        return t[v];
    endfunction

    function automatic logic [W-1:0] ref_layer(input logic [W-1:0] d);
        logic [W-1:0] r;
        for (int i = 0; i < NIB; i++) r[i*4 +: 4] = ref_nib(d[i*4 +: 4]);
        return r;
    endfunction

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string sect);
        logic [W-1:0] exp_n;
        exp_n = m_valid ? ~m_q : '0;
        chk(out_p, m_q, {sect, " R2 out_p"});
        chk(out_n, exp_n, {sect, " R7 out_n"});
        chk(data_out, m_q, {sect, " R9 data_out"});
        chk({{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, m_valid}, {sect, " R6 out_valid"});
        chk({{(W-1){1'b0}}, rail_err}, '0, {sect, " R8 rail_err"});
    endtask

    task automatic step(input logic ph, input logic [W-1:0] d, input string sect);
        @(negedge clk);
        eval_phase = ph;
        data_in    = d;
        @(posedge clk);
        if (rst_n) begin
            if (m_eval && !ph) begin
                m_q = ref_layer(d); m_valid = 1; m_eval = 0;
            end else if (!m_eval && ph) begin
                m_q = '0; m_valid = 0; m_eval = 1;
            end
        end
        #1;
        compare(sect);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        eval_phase = 1'b0;
        m_eval = 0; m_q = '0; m_valid = 0;
        @(posedge clk); #1;
        compare("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1 released");
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] d;
        do_reset();

        // R3 / R4: every code in every lane, rotated by lane index
        for (int v = 0; v < 16; v++) begin
            for (int i = 0; i < NIB; i++) d[i*4 +: 4] = 4'((v + i) % 16);
            step(1'b1, ~d, "R3");
            step(1'b1, d, "R4");
            step(1'b0, d, "R3");
            // R5: input changes in precharge must not disturb the held result
            step(1'b0, ~d, "R5");
            step(1'b0, {$urandom, $urandom}, "R5");
        end

        // R10: long precharge, no START without the phase
        for (int k = 0; k < 8; k++) step(1'b0, {$urandom, $urandom}, "R10");

        // R5: data moving during a long evaluation; only the last value counts
        step(1'b1, 64'h0123_4567_89AB_CDEF, "R6");
        for (int k = 0; k < 5; k++) step(1'b1, {$urandom, $urandom}, "R5");
        step(1'b0, 64'hFEDC_BA98_7654_3210, "R2");
        step(1'b0, '0, "R5");

        // single-cycle evaluation windows, all-ones and all-zero states
        step(1'b1, '1, "R6");
        step(1'b0, '1, "R3");
        step(1'b1, '0, "R6");
        step(1'b0, '0, "R3");

        // reset in the middle of an evaluation
        step(1'b1, 64'hA5A5_5A5A_0F0F_F0F0, "R10");
        do_reset();
        step(1'b0, 64'hA5A5_5A5A_0F0F_F0F0, "R10");

        // random phase and data
        for (int k = 0; k < 400; k++)
            step(1'($urandom % 2), {$urandom, $urandom}, "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule